// File: doc/BRIEF.md
# Linked Single-Channel Transfer Sequencer

This block moves a one-dimensional block of data elements for one channel. The work is described by a parameter set with these fields: a control word, a source address, a destination address, an element count, a frame count, an element reload value and a link field. Up to `NSETS` parameter sets are held in a small internal store. A configuration write port fills that store. A start pulse names the set to run first. After loading that set, the sequencer waits for synchronization events. Each event issues element moves on a valid/ready move-request port. After every completed move, the source and destination addresses and the counters are updated.

A block has frame-count-plus-one frames. Each frame has element-count elements. After the first frame, the element count is refilled from the reload value. The control word selects the transfer granularity. In one setting each event moves a single element. In the other setting each event drains the rest of the current frame back to back. When the block ends, the sequencer does one of two things. It returns to idle, or it fetches the next parameter set named by the link field and carries on without outside help. It can also raise a one-cycle completion strobe that carries a 4-bit code.

The controller has five states. `S_IDLE` waits for start. `S_LOAD` copies a stored set into the working registers. `S_ARM` waits for an event. `S_MOVE` presents a move request. `S_DONE` reports completion and chooses where to go next. The transitions are:
- IDLE→LOAD on start.
- LOAD→ARM always.
- ARM→MOVE on a new or latched event.
- MOVE→MOVE on an accepted move inside a frame-synchronized frame, or on a stall.
- MOVE→ARM on an accepted move that does not end the block, in element mode or at a frame end.
- MOVE→DONE on the accepted move that ends the block.
- DONE→LOAD when linking to a valid set.
- DONE→IDLE otherwise.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `mv_valid`, `tc_pulse` and `overrun` are low. A sync event while idle produces no move request.
- R2: The element size comes from control bits [1:0]: 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. `mv_size` reports 0, 1 or 2 for 1, 2 or 4 bytes.
- R3: Control bits [3:2] set the source address mode and bits [5:4] set the destination address mode. Value 1 increments by the element size after each completed move, value 2 decrements by the element size, and values 0 and 3 hold the address.
- R4: With control bit 6 clear, each sync event causes exactly one element move.
- R5: With control bit 6 set, one sync event moves all remaining elements of the current frame. While `mv_ready` stays high, these moves complete on consecutive cycles.
- R6: A block is (frame count + 1) frames. The first frame has element-count moves. Every later frame has reload-value moves. A count of 0 behaves as 1.
- R7: A move completes only in a cycle with both `mv_valid` and `mv_ready` high. While `mv_ready` is low, `mv_valid`, `mv_src`, `mv_dst` and `mv_size` stay unchanged.
- R8: With control bit 7 clear, the channel goes idle after the last move of the block. Later sync events cause no moves. A start pulse while the channel is not idle has no effect.
- R9: With control bit 7 set, the set whose index equals the link field is loaded and the channel waits for events again. A link value of `NSETS` or more behaves as if bit 7 were clear.
- R10: With control bit 8 set, `tc_pulse` is high for one cycle in the cycle after the last move of a block completes, and `tc_code` equals control bits [12:9] in that cycle. With bit 8 clear, no pulse is produced.
- R11: One sync event that arrives while the channel is busy (loading, moving or completing) is held and serviced on the next return to waiting. A further event while one is held is dropped and raises `overrun` for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for the parameter store |
| cfg_idx | input | IW | Set index to write |
| cfg_opt | input | 13 | Control word |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_ecnt | input | CW | Element count of the first frame |
| cfg_fcnt | input | CW | Frame count (frames minus one) |
| cfg_erld | input | CW | Element reload value |
| cfg_link | input | LW | Index of the next set |
| start_i | input | 1 | Start pulse |
| start_idx | input | IW | Set index to run on start |
| sync_i | input | 1 | Synchronization event |
| mv_valid | output | 1 | Move request valid |
| mv_ready | input | 1 | Move request accepted |
| mv_src | output | AW | Source address of the move |
| mv_dst | output | AW | Destination address of the move |
| mv_size | output | 2 | Element size code |
| tc_pulse | output | 1 | Block completion strobe |
| tc_code | output | 4 | Completion code |
| overrun | output | 1 | Dropped sync event |

## Verification
An incoming sync event can coincide with work the channel is already doing. It may arrive during a stalled frame burst, while a latched event is being consumed, or during the reload cycle of a linked set. In the tests, events are sent while `mv_ready` is held low in the middle of a frame-synchronized burst, and again while a link reload is in progress. The bench then counts the completed moves, the completion codes and the overrun strobes. It also compares every recorded address with a value it computes from the start address, the mode and the move index.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        AM_HOLD = 2'd0,
        AM_INC  = 2'd1,
        AM_DEC  = 2'd2,
        AM_KEEP = 2'd3
    } amode_t;

    typedef struct packed {
        logic [3:0] tc_code;
        logic       tcint;
        logic       link;
        logic       fsync;
        amode_t     dmode;
        amode_t     smode;
        logic [1:0] esize;
    } opt_t;

    localparam int OPT_W = $bits(opt_t);

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_ARM,
        S_MOVE,
        S_DONE
    } st_t;

    function automatic logic [2:0] elem_bytes(input logic [1:0] es);
        case (es)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [1:0] size_code(input logic [1:0] es);
        return (es == 2'd3) ? 2'd2 : es;
    endfunction

endpackage

// File: rtl/dma_pset_mem.sv
module dma_pset_mem
    import dma_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int LW    = 16,
    parameter int NSETS = 8,
    localparam int IW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] wr_idx,
    input  opt_t          wr_opt,
    input  logic [AW-1:0] wr_src,
    input  logic [AW-1:0] wr_dst,
    input  logic [CW-1:0] wr_ecnt,
    input  logic [CW-1:0] wr_fcnt,
    input  logic [CW-1:0] wr_erld,
    input  logic [LW-1:0] wr_link,
    input  logic [IW-1:0] rd_idx,
    output opt_t          rd_opt,
    output logic [AW-1:0] rd_src,
    output logic [AW-1:0] rd_dst,
    output logic [CW-1:0] rd_ecnt,
    output logic [CW-1:0] rd_fcnt,
    output logic [CW-1:0] rd_erld,
    output logic [LW-1:0] rd_link
);

    opt_t          opt_m  [NSETS];
    logic [AW-1:0] src_m  [NSETS];
    logic [AW-1:0] dst_m  [NSETS];
    logic [CW-1:0] ecnt_m [NSETS];
    logic [CW-1:0] fcnt_m [NSETS];
    logic [CW-1:0] erld_m [NSETS];
    logic [LW-1:0] link_m [NSETS];

    always_ff @(posedge clk) begin
        if (we) begin
            opt_m[wr_idx]  <= wr_opt;
            src_m[wr_idx]  <= wr_src;
            dst_m[wr_idx]  <= wr_dst;
            ecnt_m[wr_idx] <= wr_ecnt;
            fcnt_m[wr_idx] <= wr_fcnt;
            erld_m[wr_idx] <= wr_erld;
            link_m[wr_idx] <= wr_link;
        end
    end

    always_comb begin
        rd_opt  = opt_m[rd_idx];
        rd_src  = src_m[rd_idx];
        rd_dst  = dst_m[rd_idx];
        rd_ecnt = ecnt_m[rd_idx];
        rd_fcnt = fcnt_m[rd_idx];
        rd_erld = erld_m[rd_idx];
        rd_link = link_m[rd_idx];
    end

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic          step,
    input  amode_t        mode,
    input  logic [2:0]    nbytes,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] delta;

    assign delta = AW'(nbytes);
    assign addr  = addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= ld_addr;
        end else if (step) begin
            unique case (mode)
                AM_INC:  addr_q <= addr_q + delta;
                AM_DEC:  addr_q <= addr_q - delta;
                AM_HOLD,
                AM_KEEP: addr_q <= addr_q;
            endcase
        end
    end

    // R3: a holding mode leaves the address untouched across a move
    assert_hold_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && (mode == AM_HOLD || mode == AM_KEEP)) |=> $stable(addr_q));

    // R3: an incrementing move advances by the element byte count
    assert_inc_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == AM_INC) |=> (addr_q - $past(addr_q) == $past(delta)));

endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] ld_ecnt,
    input  logic [CW-1:0] ld_fcnt,
    input  logic [CW-1:0] ld_erld,
    input  logic          step,
    output logic          last_elem,
    output logic          last_frame,
    output logic          block_end
);

    logic [CW-1:0] ecnt_q;
    logic [CW-1:0] fcnt_q;
    logic [CW-1:0] erld_q;

    always_comb begin
        last_elem  = (ecnt_q <= CW'(1));
        last_frame = (fcnt_q == '0);
        block_end  = last_elem && last_frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt_q <= '0;
            fcnt_q <= '0;
            erld_q <= '0;
        end else if (load) begin
            ecnt_q <= ld_ecnt;
            fcnt_q <= ld_fcnt;
            erld_q <= ld_erld;
        end else if (step) begin
            if (last_elem) begin
                ecnt_q <= erld_q;
                if (!last_frame) begin
                    fcnt_q <= fcnt_q - CW'(1);
                end
            end else begin
                ecnt_q <= ecnt_q - CW'(1);
            end
        end
    end

    // R6: inside a frame each move takes one from the element count
    assert_ecnt_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !last_elem) |=> (ecnt_q == $past(ecnt_q) - CW'(1)));

    // R6: the last element of a frame refills the count and spends a frame
    assert_frame_spend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && last_elem && !last_frame) |=>
            (ecnt_q == erld_q && fcnt_q == $past(fcnt_q) - CW'(1)));

endmodule

// File: rtl/dma_sync_latch.sv
module dma_sync_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_i,
    input  logic armed,
    input  logic active,
    output logic go,
    output logic overrun
);

    logic pend_q;

    always_comb begin
        go      = armed && (sync_i || pend_q);
        overrun = active && !armed && sync_i && pend_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!active) begin
            pend_q <= 1'b0;
        end else if (armed) begin
            pend_q <= sync_i && pend_q;
        end else if (sync_i) begin
            pend_q <= 1'b1;
        end
    end

    // R11: a dropped event leaves the earlier held event in place
    assert_overrun_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> pend_q);

    // R11: a held event is never lost while waiting
    assert_pend_serviced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pend_q) |-> go);

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CW    = 16,
    parameter int LW    = 16,
    parameter int NSETS = 8,
    localparam int IW   = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic [OPT_W-1:0] cfg_opt,
    input  logic [AW-1:0]    cfg_src,
    input  logic [AW-1:0]    cfg_dst,
    input  logic [CW-1:0]    cfg_ecnt,
    input  logic [CW-1:0]    cfg_fcnt,
    input  logic [CW-1:0]    cfg_erld,
    input  logic [LW-1:0]    cfg_link,
    input  logic             start_i,
    input  logic [IW-1:0]    start_idx,
    input  logic             sync_i,
    output logic             mv_valid,
    input  logic             mv_ready,
    output logic [AW-1:0]    mv_src,
    output logic [AW-1:0]    mv_dst,
    output logic [1:0]       mv_size,
    output logic             tc_pulse,
    output logic [3:0]       tc_code,
    output logic             overrun
);

    localparam logic [LW:0] SETS_L = (LW + 1)'(NSETS);

    st_t           state_q, state_n;
    opt_t          opt_q;
    logic [LW-1:0] link_q;
    logic [IW-1:0] idx_q;

    opt_t          rd_opt;
    logic [AW-1:0] rd_src, rd_dst;
    logic [CW-1:0] rd_ecnt, rd_fcnt, rd_erld;
    logic [LW-1:0] rd_link;

    logic do_load, mv_fire, go;
    logic last_elem, last_frame, block_end;
    logic link_go;
    logic [2:0] nbytes;

    dma_pset_mem #(.AW(AW), .CW(CW), .LW(LW), .NSETS(NSETS)) u_mem (
        .clk     (clk),
        .we      (cfg_we),
        .wr_idx  (cfg_idx),
        .wr_opt  (opt_t'(cfg_opt)),
        .wr_src  (cfg_src),
        .wr_dst  (cfg_dst),
        .wr_ecnt (cfg_ecnt),
        .wr_fcnt (cfg_fcnt),
        .wr_erld (cfg_erld),
        .wr_link (cfg_link),
        .rd_idx  (idx_q),
        .rd_opt  (rd_opt),
        .rd_src  (rd_src),
        .rd_dst  (rd_dst),
        .rd_ecnt (rd_ecnt),
        .rd_fcnt (rd_fcnt),
        .rd_erld (rd_erld),
        .rd_link (rd_link)
    );

    dma_xfer_cnt #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (do_load),
        .ld_ecnt    (rd_ecnt),
        .ld_fcnt    (rd_fcnt),
        .ld_erld    (rd_erld),
        .step       (mv_fire),
        .last_elem  (last_elem),
        .last_frame (last_frame),
        .block_end  (block_end)
    );

    dma_sync_latch u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_i),
        .armed   (state_q == S_ARM),
        .active  (state_q != S_IDLE),
        .go      (go),
        .overrun (overrun)
    );

    // address engines: index 0 is the source side, index 1 the destination side
    logic [AW-1:0] ld_addr [2];
    amode_t        amode   [2];
    logic [AW-1:0] cur     [2];

    assign ld_addr[0] = rd_src;
    assign ld_addr[1] = rd_dst;
    assign amode[0]   = opt_q.smode;
    assign amode[1]   = opt_q.dmode;

    for (genvar g = 0; g < 2; g++) begin : g_addr
        dma_addr_unit #(.AW(AW)) u_addr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (do_load),
            .ld_addr (ld_addr[g]),
            .step    (mv_fire),
            .mode    (amode[g]),
            .nbytes  (nbytes),
            .addr    (cur[g])
        );
    end

    assign nbytes  = elem_bytes(opt_q.esize);
    assign link_go = opt_q.link && ({1'b0, link_q} < SETS_L);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // working copy of the control word, link field and set index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q  <= '0;
            link_q <= '0;
            idx_q  <= '0;
        end else begin
            if (state_q == S_IDLE && start_i) begin
                idx_q <= start_idx;
            end else if (state_q == S_DONE && link_go) begin
                idx_q <= link_q[IW-1:0];
            end
            if (state_q == S_LOAD) begin
                opt_q  <= rd_opt;
                link_q <= rd_link;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_n  = state_q;
        do_load  = 1'b0;
        mv_valid = 1'b0;
        mv_fire  = 1'b0;
        tc_pulse = 1'b0;
        tc_code  = 4'd0;
        mv_src   = cur[0];
        mv_dst   = cur[1];
        mv_size  = size_code(opt_q.esize);
        unique case (state_q)
            S_IDLE: begin
                if (start_i) state_n = S_LOAD;
            end
            S_LOAD: begin
                do_load = 1'b1;
                state_n = S_ARM;
            end
            S_ARM: begin
                if (go) state_n = S_MOVE;
            end
            S_MOVE: begin
                mv_valid = 1'b1;
                if (mv_ready) begin
                    mv_fire = 1'b1;
                    if (block_end) begin
                        state_n = S_DONE;
                    end else if (last_elem || !opt_q.fsync) begin
                        state_n = S_ARM;
                    end
                end
            end
            S_DONE: begin
                tc_pulse = opt_q.tcint;
                tc_code  = opt_q.tcint ? opt_q.tc_code : 4'd0;
                state_n  = link_go ? S_LOAD : S_IDLE;
            end
            default: state_n = S_IDLE;
        endcase
    end

    // R7: a stalled request keeps its contents
    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && !mv_ready) |=>
            (mv_valid && $stable(mv_src) && $stable(mv_dst) && $stable(mv_size)));

    // R5: a frame-synchronized burst keeps requesting until the frame ends
    assert_burst_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && mv_ready && opt_q.fsync && !last_elem) |=> mv_valid);

    // R4: an element-synchronized move is followed by a gap in requests
    assert_elem_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && mv_ready && !opt_q.fsync) |=> !mv_valid);

    // R10: completion strobe only right after an accepted move
    assert_tc_follows_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(mv_valid && mv_ready));

    // R10: completion strobe lasts one cycle and no request shares the next one
    assert_tc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> (!tc_pulse && !mv_valid));

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
    import dma_seq_pkg::*;

    localparam int AW = 32, CW = 16, LW = 16, NSETS = 8, IW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [IW-1:0]    cfg_idx = '0;
    logic [OPT_W-1:0] cfg_opt = '0;
    logic [AW-1:0]    cfg_src = '0, cfg_dst = '0;
    logic [CW-1:0]    cfg_ecnt = '0, cfg_fcnt = '0, cfg_erld = '0;
    logic [LW-1:0]    cfg_link = '0;
    logic             start_i = 1'b0;
    logic [IW-1:0]    start_idx = '0;
    logic             sync_i = 1'b0;
    logic             mv_ready = 1'b1;
    logic             mv_valid, tc_pulse, overrun;
    logic [AW-1:0]    mv_src, mv_dst;
    logic [1:0]       mv_size;
    logic [3:0]       tc_code;

    always #5 clk = ~clk;

    dma_chan_seq #(.AW(AW), .CW(CW), .LW(LW), .NSETS(NSETS)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_opt(cfg_opt),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_ecnt(cfg_ecnt), .cfg_fcnt(cfg_fcnt),
        .cfg_erld(cfg_erld), .cfg_link(cfg_link), .start_i(start_i), .start_idx(start_idx),
        .sync_i(sync_i), .mv_valid(mv_valid), .mv_ready(mv_ready), .mv_src(mv_src),
        .mv_dst(mv_dst), .mv_size(mv_size), .tc_pulse(tc_pulse), .tc_code(tc_code),
        .overrun(overrun)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int mon_n = 0, tc_n = 0, ovr_n = 0;
    logic [AW-1:0] rec_src [0:1023];
    logic [AW-1:0] rec_dst [0:1023];
    logic [1:0]    rec_sz  [0:1023];
    int            rec_cyc [0:1023];
    logic [3:0]    tc_rec  [0:255];
    logic pv = 1'b0, pr = 1'b0;
    logic [AW-1:0] ps = '0, pd = '0;

    // monitor, away from the active edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (pv && !pr) begin
                n_chk++;
                if (!(mv_valid && mv_src == ps && mv_dst == pd)) begin
                    n_bad++;
                    $display("FAIL R7 stalled request changed: actual v=%0b src=%h dst=%h expected v=1 src=%h dst=%h",
                             mv_valid, mv_src, mv_dst, ps, pd);
                end
            end
            if (mv_valid && mv_ready && mon_n < 1024) begin
                rec_src[mon_n] = mv_src;
                rec_dst[mon_n] = mv_dst;
                rec_sz[mon_n]  = mv_size;
                rec_cyc[mon_n] = cyc;
                mon_n++;
            end
            if (tc_pulse && tc_n < 256) begin
                tc_rec[tc_n] = tc_code;
                tc_n++;
            end
            if (overrun) ovr_n++;
            pv = mv_valid; pr = mv_ready; ps = mv_src; pd = mv_dst;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic [OPT_W-1:0] mk_opt(input int es, input int sm, input int dm,
                                                input int fs, input int lk, input int ti, input int code);
        return {4'(code), 1'(ti), 1'(lk), 1'(fs), 2'(dm), 2'(sm), 2'(es)};
    endfunction

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a0, input int m, input int es, input int k);
        int b;
        b = (es == 0) ? 1 : (es == 1) ? 2 : 4;
        case (m)
            1:       return a0 + AW'(k * b);
            2:       return a0 - AW'(k * b);
            default: return a0;
        endcase
    endfunction

    task automatic wr_set(input int idx, input logic [OPT_W-1:0] o, input logic [AW-1:0] s,
                          input logic [AW-1:0] d, input int ec, input int fc, input int er, input int lk);
        tick(1);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_opt = o; cfg_src = s; cfg_dst = d;
        cfg_ecnt = CW'(ec); cfg_fcnt = CW'(fc); cfg_erld = CW'(er); cfg_link = LW'(lk);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic start_set(input int idx);
        start_idx = IW'(idx); start_i = 1'b1;
        tick(1);
        start_i = 1'b0;
        tick(2);
    endtask

    task automatic pulse_sync();
        sync_i = 1'b1;
        tick(1);
        sync_i = 1'b0;
    endtask

    task automatic check_moves(input string req, input int base, input int k0, input int n,
                               input logic [AW-1:0] s0, input logic [AW-1:0] d0,
                               input int es, input int sm, input int dm);
        for (int i = 0; i < n; i++) begin
            chk(req, "move source", rec_src[base + i], exp_addr(s0, sm, es, k0 + i));
            chk(req, "move destination", rec_dst[base + i], exp_addr(d0, dm, es, k0 + i));
            chk("R2", "move size code", rec_sz[base + i], (es == 3) ? 2 : es);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual run still active, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int base, tb, ob;
        logic [AW-1:0] S0, D0;
        S0 = 32'h1000_0100;
        D0 = 32'h2000_0800;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", mv_valid, 0);
        chk("R1", "tc after reset", tc_pulse, 0);
        chk("R1", "overrun after reset", overrun, 0);
        pulse_sync();
        tick(4);
        chk("R1", "moves from idle sync", mon_n, 0);

        // sweep of size and both address modes, element synchronized
        for (int es = 0; es < 4; es++) begin
            for (int sm = 0; sm < 4; sm++) begin
                for (int dm = 0; dm < 4; dm++) begin
                    int code;
                    code = (es * 16 + sm * 4 + dm) % 16;
                    wr_set(0, mk_opt(es, sm, dm, 0, 0, 1, code), S0, D0, 2, 1, 2, 0);
                    base = mon_n; tb = tc_n;
                    start_set(0);
                    for (int e = 0; e < 4; e++) begin
                        pulse_sync();
                        tick(3);
                        chk("R4", "moves per event", mon_n - base, e + 1);
                    end
                    tick(2);
                    chk("R10", "tc count", tc_n - tb, 1);
                    chk("R10", "tc code", tc_rec[tb], code);
                    check_moves("R3", base, 0, 4, S0, D0, es, sm, dm);
                end
            end
        end

        // reload value differs from first frame count
        wr_set(1, mk_opt(2, 1, 1, 0, 0, 1, 3), S0, D0, 2, 2, 3, 0);
        base = mon_n; tb = tc_n;
        start_set(1);
        for (int e = 0; e < 8; e++) begin
            if (e == 7) chk("R6", "tc before last move", tc_n - tb, 0);
            pulse_sync();
            tick(3);
        end
        tick(2);
        chk("R6", "moves in block", mon_n - base, 8);
        chk("R10", "tc after block", tc_n - tb, 1);
        check_moves("R6", base, 0, 8, S0, D0, 2, 1, 1);
        pulse_sync();
        tick(4);
        chk("R8", "moves after stop", mon_n - base, 8);

        // zero counts act as one
        wr_set(1, mk_opt(1, 1, 2, 0, 0, 0, 0), S0, D0, 0, 1, 0, 0);
        base = mon_n;
        start_set(1);
        for (int e = 0; e < 3; e++) begin
            pulse_sync();
            tick(3);
        end
        chk("R6", "moves with zero counts", mon_n - base, 2);

        // frame synchronized, no completion strobe
        wr_set(2, mk_opt(1, 1, 2, 1, 0, 0, 6), S0, D0, 3, 1, 3, 0);
        base = mon_n; tb = tc_n;
        start_set(2);
        pulse_sync();
        tick(8);
        chk("R5", "moves from one event", mon_n - base, 3);
        chk("R5", "burst spacing 1", rec_cyc[base + 1] - rec_cyc[base], 1);
        chk("R5", "burst spacing 2", rec_cyc[base + 2] - rec_cyc[base + 1], 1);
        pulse_sync();
        tick(8);
        chk("R5", "moves after two events", mon_n - base, 6);
        chk("R10", "no tc with strobe disabled", tc_n - tb, 0);
        check_moves("R5", base, 0, 6, S0, D0, 1, 1, 2);

        // stalls inside a burst
        wr_set(3, mk_opt(0, 1, 1, 1, 0, 1, 12), S0, D0, 5, 0, 5, 0);
        base = mon_n; tb = tc_n;
        mv_ready = 1'b0;
        start_set(3);
        pulse_sync();
        for (int c = 0; c < 40; c++) begin
            mv_ready = (c % 3 == 2);
            tick(1);
        end
        mv_ready = 1'b1;
        tick(3);
        chk("R7", "moves under stalls", mon_n - base, 5);
        chk("R10", "tc after stalled block", tc_rec[tb], 12);
        check_moves("R7", base, 0, 5, S0, D0, 0, 1, 1);

        // linking from set 1 to set 6
        wr_set(1, mk_opt(2, 1, 1, 0, 1, 1, 5), S0, D0, 1, 1, 1, 6);
        wr_set(6, mk_opt(1, 2, 2, 0, 0, 1, 9), 32'h3000_0040, 32'h4000_0080, 2, 0, 2, 0);
        base = mon_n; tb = tc_n;
        start_set(1);
        for (int e = 0; e < 4; e++) begin
            pulse_sync();
            tick(6);
        end
        chk("R9", "moves across link", mon_n - base, 4);
        chk("R9", "tc count across link", tc_n - tb, 2);
        chk("R9", "first tc code", tc_rec[tb], 5);
        chk("R9", "second tc code", tc_rec[tb + 1], 9);
        check_moves("R9", base, 0, 2, S0, D0, 2, 1, 1);
        check_moves("R9", base + 2, 0, 2, 32'h3000_0040, 32'h4000_0080, 1, 2, 2);

        // sync during link reload is held
        wr_set(1, mk_opt(2, 1, 1, 0, 1, 0, 0), S0, D0, 1, 0, 1, 6);
        base = mon_n;
        start_set(1);
        pulse_sync();
        pulse_sync();
        tick(8);
        chk("R11", "sync held over reload", mon_n - base, 2);
        chk("R11", "linked move source", rec_src[base + 1], 32'h3000_0040);
        pulse_sync();
        tick(4);

        // link out of range stops
        wr_set(2, mk_opt(2, 1, 1, 0, 1, 1, 7), S0, D0, 1, 0, 1, 16'h0100);
        base = mon_n; tb = tc_n;
        start_set(2);
        pulse_sync();
        tick(5);
        pulse_sync();
        tick(5);
        chk("R9", "moves with bad link", mon_n - base, 1);
        chk("R9", "tc with bad link", tc_rec[tb], 7);

        // held event and overrun during a stalled burst; start ignored while busy
        wr_set(4, mk_opt(2, 1, 1, 1, 0, 1, 10), S0, D0, 4, 1, 4, 0);
        wr_set(5, mk_opt(2, 0, 0, 1, 0, 1, 1), 32'h5000_0000, 32'h6000_0000, 4, 1, 4, 0);
        base = mon_n; tb = tc_n; ob = ovr_n;
        mv_ready = 1'b0;
        start_set(4);
        pulse_sync();
        tick(2);
        pulse_sync();
        tick(2);
        chk("R11", "no overrun on first held event", ovr_n - ob, 0);
        pulse_sync();
        tick(2);
        chk("R11", "overrun on second held event", ovr_n - ob, 1);
        start_set(5);
        mv_ready = 1'b1;
        tick(20);
        chk("R11", "moves with held event", mon_n - base, 8);
        chk("R10", "tc after held event block", tc_n - tb, 1);
        check_moves("R8", base, 0, 8, S0, D0, 2, 1, 1);
        pulse_sync();
        tick(5);
        chk("R8", "idle sync after block", mon_n - base, 8);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule